// File: doc/BRIEF.md
# Dual-Channel Converter Serial Readout Controller

This controller sits on the host side of a dual simultaneous-sampling converter that has a shared chip-select and serial clock and a separate serial data line for each of its two channels. A single-cycle start request makes the controller drive the channel-pair select, range and single-ended/differential lines. It then lowers chip-select and runs a burst of serial clock cycles. On every rising serial clock edge it samples both data lines together.

Each frame starts with three zero bits, then 12 result bits, most significant bit first, and can end with an optional trailing zero. The controller removes the zero bits and checks that they really are zero. It presents both 12-bit results and a framing error flag with a one-cycle valid strobe, as soon as chip-select has returned high. The serial clock is derived from the system clock. Its half period is a whole number of system clock cycles, set by an input.

Top module: `dual_adc_reader`

## Requirements
- R1: In reset and afterwards until a start is taken, cs_n and sclk are 1, valid and busy are 0, and word_a, word_b and frame_err are 0.
- R2: A start taken in idle latches chan_in, range_in and single_in onto chan_sel, range_sel and single_ended. These outputs are already stable for at least one system clock when cs_n falls, and they do not change while cs_n is low.
- R3: While cs_n is low, sclk is high for `half` system clocks after cs_n falls. After that, each serial clock cycle is `half` clocks low followed by `half` clocks high. `half` equals div, or 1 when div is 0.
- R4: The number of rising sclk edges in one cs_n low period is 16 when long_frame was 1 at start, and 15 when it was 0.
- R5: The target changes each data bit after a falling sclk edge, and the controller samples both lines on the next rising edge. The first three sampled bits are leading bits. The next 12 bits form the result, MSB first: word_a comes from sdata_a and word_b from sdata_b.
- R6: frame_err is 1 when any leading bit on either line is 1. In 16-cycle frames it is also 1 when the trailing bit on either line is 1. In 15-cycle frames the trailing bit is never sampled and has no effect.
- R7: valid is high for exactly one cycle, which is the first cycle with cs_n high after a frame. word_a, word_b and frame_err hold their values until the next valid.
- R8: Between frames, cs_n stays high for at least 2*half system clocks. busy is 1 from the cycle after a start is taken until the controller is ready for the next start.
- R9: A start request while busy is ignored. It causes no extra frame and no change to the control lines.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Request one readout frame |
| long_frame | input | 1 | 1 = 16-cycle frame, 0 = 15-cycle frame |
| chan_in | input | 3 | Channel pair to convert |
| range_in | input | 1 | Range choice: 0 = one times reference, 1 = twice the reference |
| single_in | input | 1 | 1 = single-ended inputs, 0 = differential inputs |
| div | input | DIV_W | Serial clock half period in system clocks (0 is treated as 1) |
| sdata_a | input | 1 | Serial data from converter A |
| sdata_b | input | 1 | Serial data from converter B |
| cs_n | output | 1 | Active-low chip-select |
| sclk | output | 1 | Serial clock, high when idle |
| chan_sel | output | 3 | Latched channel pair select |
| range_sel | output | 1 | Latched range line |
| single_ended | output | 1 | Latched single/differential line |
| busy | output | 1 | Frame or inter-frame gap in progress |
| valid | output | 1 | One-cycle result strobe |
| word_a | output | DATA_W | Result from converter A |
| word_b | output | DATA_W | Result from converter B |
| frame_err | output | 1 | Nonzero leading or trailing bit seen |

## Verification
The hardest case to reach is a framing error that comes only from the trailing bit. It must be flagged in a 16-cycle frame and must go unseen in a 15-cycle frame. Both cases only show up if the target drives a nonzero bit in a slot that the controller may not sample at all.

The bench uses a behavioural converter model that builds each frame around the expected result words. It can plant a 1 in a leading slot or in the trailing slot, and it is run with the same planted bit under both frame lengths. A second start pulse is issued in the middle of a frame with different control values. This shows that the request is dropped: no extra result reaches the scoreboard, and the model sees no control change at the next cs_n fall.

// File: rtl/dual_adc_reader.sv
module dual_adc_reader #(
  parameter int DATA_W = 12,
  parameter int LEAD   = 3,
  parameter int DIV_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              long_frame,
  input  logic [2:0]        chan_in,
  input  logic              range_in,
  input  logic              single_in,
  input  logic [DIV_W-1:0]  div,
  input  logic              sdata_a,
  input  logic              sdata_b,
  output logic              cs_n,
  output logic              sclk,
  output logic [2:0]        chan_sel,
  output logic              range_sel,
  output logic              single_ended,
  output logic              busy,
  output logic              valid,
  output logic [DATA_W-1:0] word_a,
  output logic [DATA_W-1:0] word_b,
  output logic              frame_err
);

  localparam int SH_W  = LEAD + DATA_W + 1;
  localparam int BIT_W = $clog2(SH_W + 1);
  localparam int CNT_W = DIV_W + 1;

  typedef enum logic [2:0] {S_IDLE, S_SETUP, S_LEAD, S_LOW, S_HIGH, S_GAP} state_t;

  state_t           state;
  logic [CNT_W-1:0] cnt;
  logic [BIT_W-1:0] bitn;
  logic             long_q;
  logic [SH_W-1:0]  sh_a, sh_b;

  logic [CNT_W-1:0] half, half_end, gap_end;
  logic [BIT_W-1:0] last_bit;
  logic             done;

  assign half     = (div == '0) ? CNT_W'(1) : {1'b0, div};
  assign half_end = half - CNT_W'(1);
  assign gap_end  = (half << 1) - CNT_W'(1);
  assign done     = (cnt == half_end);
  assign last_bit = long_q ? BIT_W'(SH_W - 1) : BIT_W'(SH_W - 2);
  assign busy     = (state != S_IDLE);

  logic [LEAD-1:0]   lead_a, lead_b;
  logic [DATA_W-1:0] dat_a, dat_b;
  logic              trl_a, trl_b, err_now;

  assign lead_a  = long_q ? sh_a[SH_W-1 -: LEAD] : sh_a[SH_W-2 -: LEAD];
  assign lead_b  = long_q ? sh_b[SH_W-1 -: LEAD] : sh_b[SH_W-2 -: LEAD];
  assign dat_a   = long_q ? sh_a[DATA_W:1] : sh_a[DATA_W-1:0];
  assign dat_b   = long_q ? sh_b[DATA_W:1] : sh_b[DATA_W-1:0];
  assign trl_a   = long_q & sh_a[0];
  assign trl_b   = long_q & sh_b[0];
  assign err_now = (|lead_a) | (|lead_b) | trl_a | trl_b;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state        <= S_IDLE;
      cnt          <= '0;
      bitn         <= '0;
      long_q       <= 1'b0;
      sh_a         <= '0;
      sh_b         <= '0;
      cs_n         <= 1'b1;
      sclk         <= 1'b1;
      chan_sel     <= '0;
      range_sel    <= 1'b0;
      single_ended <= 1'b0;
      valid        <= 1'b0;
      word_a       <= '0;
      word_b       <= '0;
      frame_err    <= 1'b0;
    end else begin
      valid <= 1'b0;
      case (state)
        S_IDLE: if (start) begin
          chan_sel     <= chan_in;
          range_sel    <= range_in;
          single_ended <= single_in;
          long_q       <= long_frame;
          state        <= S_SETUP;
        end
        S_SETUP: begin
          cs_n  <= 1'b0;
          cnt   <= '0;
          bitn  <= '0;
          sh_a  <= '0;
          sh_b  <= '0;
          state <= S_LEAD;
        end
        S_LEAD: if (done) begin
          cnt   <= '0;
          sclk  <= 1'b0;
          state <= S_LOW;
        end else cnt <= cnt + CNT_W'(1);
        S_LOW: if (done) begin
          cnt   <= '0;
          sclk  <= 1'b1;
          sh_a  <= {sh_a[SH_W-2:0], sdata_a};
          sh_b  <= {sh_b[SH_W-2:0], sdata_b};
          state <= S_HIGH;
        end else cnt <= cnt + CNT_W'(1);
        S_HIGH: if (done) begin
          cnt <= '0;
          if (bitn == last_bit) begin
            cs_n      <= 1'b1;
            valid     <= 1'b1;
            word_a    <= dat_a;
            word_b    <= dat_b;
            frame_err <= err_now;
            state     <= S_GAP;
          end else begin
            sclk  <= 1'b0;
            bitn  <= bitn + BIT_W'(1);
            state <= S_LOW;
          end
        end else cnt <= cnt + CNT_W'(1);
        S_GAP: if (cnt == gap_end) begin
          cnt   <= '0;
          state <= S_IDLE;
        end else cnt <= cnt + CNT_W'(1);
        default: state <= S_IDLE;
      endcase
    end
  end

  AST_IDLE_FRAME_CLOSED: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_IDLE) |-> (cs_n && sclk && !valid)) else $error("idle lines"); // R1
  AST_CTRL_SETUP: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cs_n) |-> ($stable(chan_sel) && $stable(range_sel) && $stable(single_ended))) else $error("ctrl setup"); // R2
  AST_CTRL_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (!cs_n && !$past(cs_n)) |-> ($stable(chan_sel) && $stable(range_sel) && $stable(single_ended))) else $error("ctrl held"); // R2
  AST_SCLK_IDLE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |-> sclk) else $error("sclk while deselected"); // R3
  AST_VALID_AT_CS_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    valid |-> $rose(cs_n)) else $error("valid timing"); // R7
  AST_VALID_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    valid |=> !valid) else $error("valid width"); // R7
  AST_BUSY_START_DROPPED: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start && state != S_GAP) |=> $stable(chan_sel)) else $error("start while busy"); // R9

endmodule

// File: tb/test_dual_adc_reader.sv
module test_dual_adc_reader;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0, long_frame = 1'b0;
  logic [2:0] chan_in = '0;
  logic range_in = 1'b0, single_in = 1'b0;
  logic [7:0] div = 8'd1;
  logic sdata_a = 1'b0, sdata_b = 1'b0;
  logic cs_n, sclk, range_sel, single_ended, busy, valid, frame_err;
  logic [2:0] chan_sel;
  logic [11:0] word_a, word_b;

  always #(CLK_PERIOD/2) clk = ~clk;

  dual_adc_reader i_dual_adc_reader (
    .clk(clk), .rst_n(rst_n), .start(start), .long_frame(long_frame),
    .chan_in(chan_in), .range_in(range_in), .single_in(single_in), .div(div),
    .sdata_a(sdata_a), .sdata_b(sdata_b), .cs_n(cs_n), .sclk(sclk),
    .chan_sel(chan_sel), .range_sel(range_sel), .single_ended(single_ended),
    .busy(busy), .valid(valid), .word_a(word_a), .word_b(word_b), .frame_err(frame_err));

  int n_chk = 0, n_fail = 0, n_valid = 0, n_frames = 0;
  logic [24:0] sb[$];

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // converter model
  logic [15:0] fa, fb, m_fa, m_fb;
  logic [4:0] exp_ctrl;
  int exp_len = 15, exp_half = 1, gap_half = 0;
  int k = 0, rises = 0, lows = 0, highs = 0, gapcnt = 0;
  bit in_frame = 0, seen = 0;

  always @(negedge cs_n) if (rst_n) begin
    chk("R2 control lines at cs_n fall", {27'd0, chan_sel, range_sel, single_ended}, {27'd0, exp_ctrl});
    if (seen) chk("R8 cs_n high gap", (gapcnt >= 2*gap_half) ? 1 : 0, 1);
    fa = m_fa; fb = m_fb;
    sdata_a <= 1'b0; sdata_b <= 1'b0;
    k = 0; rises = 0; lows = 0; highs = 0; in_frame = 1;
  end

  always @(negedge sclk) if (!cs_n && k < 16) begin
    sdata_a <= fa[15-k];
    sdata_b <= fb[15-k];
    k++;
  end

  always @(posedge sclk) if (!cs_n) rises++;

  always @(negedge clk) begin
    if (!cs_n) begin
      if (sclk) highs++; else lows++;
    end else gapcnt++;
  end

  always @(posedge cs_n) if (in_frame) begin
    in_frame = 0; seen = 1; gapcnt = 0; gap_half = exp_half;
    chk("R4 rising sclk edges per frame", rises, exp_len);
    chk("R3 sclk low cycles", lows, exp_len*exp_half);
    chk("R3 sclk high cycles", highs, (exp_len+1)*exp_half);
  end

  // scoreboard monitor
  logic [24:0] got_item;
  logic [24:0] exp_item;
  always @(negedge clk) if (rst_n && valid) begin
    n_valid++;
    chk("R7 valid with cs_n high", {31'd0, cs_n}, 1);
    if (sb.size() == 0) chk("R9 unexpected result", 1, 0);
    else begin
      exp_item = sb.pop_front();
      got_item = {frame_err, word_a, word_b};
      chk("R5 word_a", {20'd0, word_a}, {20'd0, exp_item[23:12]});
      chk("R5 word_b", {20'd0, word_b}, {20'd0, exp_item[11:0]});
      chk("R6 frame_err", {31'd0, frame_err}, {31'd0, exp_item[24]});
    end
    @(negedge clk);
    chk("R7 valid one cycle", {31'd0, valid}, 0);
    chk("R7 result held", {7'd0, frame_err, word_a, word_b}, {7'd0, got_item});
  end

  task automatic frame(input logic [11:0] a, input logic [11:0] b, input logic [2:0] ch,
                       input logic rg, input logic sg, input logic lg,
                       input logic bad_lead, input logic bad_trail, input int dv, input bit mid);
    div = dv[7:0];
    m_fa = {1'b0, bad_lead, 1'b0, a, bad_trail};
    m_fb = {2'b00, 1'b0, b, bad_trail};
    exp_ctrl = {ch, rg, sg};
    exp_len = lg ? 16 : 15;
    exp_half = (dv == 0) ? 1 : dv;
    sb.push_back({bad_lead | (lg & bad_trail), a, b});
    n_frames++;
    @(negedge clk);
    start = 1; chan_in = ch; range_in = rg; single_in = sg; long_frame = lg;
    @(negedge clk);
    start = 0; chan_in = ~ch; range_in = ~rg; single_in = ~sg; long_frame = ~lg;
    if (mid) begin
      repeat (6) @(negedge clk);
      start = 1;
      @(negedge clk);
      start = 0;
    end
    do @(negedge clk); while (busy);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 reset cs_n", {31'd0, cs_n}, 1);
    chk("R1 reset sclk", {31'd0, sclk}, 1);
    chk("R1 reset valid/busy/err", {29'd0, valid, busy, frame_err}, 0);
    chk("R1 reset words", {8'd0, word_a, word_b}, 0);
    rst_n = 1;
    repeat (3) @(negedge clk);
    chk("R1 idle after reset", {30'd0, cs_n, busy}, 32'd2);

    frame(12'hA5C, 12'h3C1, 3'd1, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1, 0);
    frame(12'hFFF, 12'h000, 3'd5, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 2, 0);
    frame(12'h000, 12'hFFF, 3'd7, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 0, 0);
    frame(12'h801, 12'h180, 3'd2, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 3, 0);
    // R6: leading-bit error in both frame lengths
    frame(12'h123, 12'h456, 3'd3, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 1, 0);
    frame(12'h789, 12'hABC, 3'd4, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 2, 0);
    // R6: trailing bit flagged only in long frames
    frame(12'h555, 12'hAAA, 3'd6, 1'b0, 1'b1, 1'b1, 1'b0, 1'b1, 1, 0);
    frame(12'h555, 12'hAAA, 3'd6, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 1, 0);
    // R9: start pulse mid-frame is dropped
    frame(12'h0F0, 12'hF0F, 3'd0, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 2, 1);
    frame(12'h3A7, 12'hC58, 3'd1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 4, 1);
    frame(12'h001, 12'h800, 3'd2, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 1, 0);

    repeat (20) @(negedge clk);
    chk("R9 result count", n_valid, n_frames);
    chk("R7 scoreboard drained", sb.size(), 0);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule